// File: doc/BRIEF.md
# Split-Field Shared-Tap Pulse-Width Modulator

This block turns a 4-bit duty code into a pulse train with a period of 16 clock cycles. The pulse is high for exactly as many cycles as the code's value. The code is split into an upper pair and a lower pair, so the value is 4 × upper + lower. Each pair drives its own small 2-bit slicer.

Both slicers take their timing from one shared two-flop tap line. This line is a twisted-ring counter that marks four fine slots. Each slicer has its own divide-by-4 quarter counter. A slicer's counter is held cleared while that slicer's pair is zero. The upper slicer fills whole quarters at the start of the period. The lower slicer adds single cycles in the quarter that follows them. A combiner then drives either the lower contribution alone or the OR of both, chosen by the code.

The duty code is taken once per period. A new value can therefore arrive at any time without cutting a pulse short. A one-cycle strobe marks the first cycle of every period.

Top module: `split_pwm`

## Requirements
- R1: `period_strobe` is high for one cycle in every 16, and the cycles between two strobes number exactly 15.
- R2: In each period, `pwm_out` is high for exactly V cycles, where V = 8·d[3] + 4·d[2] + 2·d[1] + d[0] of the code in force for that period. This gives 16 levels, from 0/16 to 15/16.
- R3: The high time starts in the strobe cycle and forms one unbroken run. The 4·upper cycles of the upper pair come first, and the lower-pair cycles follow directly with no gap.
- R4: A code of 0 keeps `pwm_out` low for the whole period. This includes codes whose upper pair is zero while the lower pair is not, for which the pulse is just the lower-pair count.
- R5: `duty_set` is sampled only at the clock edge that closes period index 14, the cycle two before the next strobe. That value governs the whole next period. A change made in period index 15 waits one further period.
- R6: While `rst_n` is low, both outputs are low. The first full period after reset has a code of 0, whatever `duty_set` holds.
- R7: The largest code, 15, gives 15 high cycles followed by exactly one low cycle per period. The output never stays high for a whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_set | input | 4 | Duty code: bits 3:2 are the upper pair (weight 4), bits 1:0 the lower pair (weight 1) |
| pwm_out | output | 1 | Registered pulse output |
| period_strobe | output | 1 | Registered one-cycle marker of each period's first cycle |

## Verification
The assertions take for granted that `duty_set` is a plain synchronous level that may change in any cycle. They assume no handshake governs it, and they rely only on the per-period sampling to keep each period's code fixed. They also assume reset is held for at least one edge before the first count.

The stimulus drives every input change one nanosecond after a rising edge. It holds each value for at least one full cycle, so the sampling edge always sees a settled code. The changes fall at chosen and random positions inside a period, including the two positions on either side of the sampling edge.

// File: rtl/split_pwm_pkg.sv
package split_pwm_pkg;
  // Width of one half of the duty code (one slicer's control field).
  parameter int HALF_W = 2;
  // Whole duty code width.
  localparam int TOTAL_W = 2 * HALF_W;
  // Fine slots per quarter; also the quarters per period.
  localparam int TAPS = 1 << HALF_W;
  // Output period in clock cycles.
  localparam int PERIOD = TAPS * TAPS;
  // Flops in the shared twisted-ring tap line.
  localparam int RING_N = (TAPS / 2 < 1) ? 1 : TAPS / 2;
endpackage

// File: rtl/tap_delay_line.sv
// Shared fine-slot generator: a twisted-ring of RING_N flops walks through
// TAPS states; the decoded slot drives a "slot below j" tap vector.
module tap_delay_line
  import split_pwm_pkg::*;
#(
  parameter int W     = HALF_W,
  parameter int NTAP  = TAPS,
  parameter int NRING = RING_N
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NTAP-1:0] below_tap,
  output logic            slot_first,
  output logic            slot_last
);
  localparam int IDX_W = W;

  logic [NRING-1:0] ring_q;
  logic [IDX_W-1:0] slot_idx;

  generate
    if (NRING == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ~ring_q;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= {ring_q[NRING-2:0], ~ring_q[NRING-1]};
      end
    end
  endgenerate

  // Decode the twisted-ring state into a slot number.
  always_comb begin
    int ones;
    ones = $countones(ring_q);
    if (ring_q[NRING-1]) slot_idx = IDX_W'(NTAP - ones);
    else                 slot_idx = IDX_W'(ones);
  end

  // below_tap[j] is high while the current slot index is below j.
  generate
    for (genvar j = 0; j < NTAP; j++) begin : g_tap
      assign below_tap[j] = (int'(slot_idx) < j);
    end
  endgenerate

  assign slot_first = (slot_idx == '0);
  assign slot_last  = (slot_idx == IDX_W'(NTAP - 1));
endmodule

// File: rtl/quarter_divider.sv
// Divide-by-TAPS quarter counter, advanced on each fine-slot wrap and held
// cleared while its hold input is set.
module quarter_divider
  import split_pwm_pkg::*;
#(
  parameter int W = HALF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         advance,
  output logic [W-1:0] quarter
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       quarter <= '0;
    else if (hold)    quarter <= '0;
    else if (advance) quarter <= quarter + 1'b1;
  end
endmodule

// File: rtl/coarse_slicer.sv
// Upper-pair slicer: active for the first `code` whole quarters.
module coarse_slicer
  import split_pwm_pkg::*;
#(
  parameter int W = HALF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code,
  input  logic         slot_last,
  output logic         active
);
  logic         code_zero;
  logic [W-1:0] quarter;

  assign code_zero = ~|code;

  quarter_divider #(.W(W)) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (code_zero),
    .advance (slot_last),
    .quarter (quarter)
  );

  assign active = !code_zero && (quarter < code);
endmodule

// File: rtl/fine_slicer.sv
// Lower-pair slicer: active in quarter `window` for the first `code` slots,
// picked from the shared tap line through a TAPS:1 selector.
module fine_slicer
  import split_pwm_pkg::*;
#(
  parameter int W    = HALF_W,
  parameter int NTAP = TAPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    code,
  input  logic [W-1:0]    window,
  input  logic [NTAP-1:0] below_tap,
  input  logic            slot_last,
  output logic            active
);
  logic         code_zero;
  logic [W-1:0] quarter;
  logic         tap_sel;

  assign code_zero = ~|code;

  quarter_divider #(.W(W)) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (code_zero),
    .advance (slot_last),
    .quarter (quarter)
  );

  assign tap_sel = below_tap[code];
  assign active  = !code_zero && (quarter == window) && tap_sel;
endmodule

// File: rtl/split_pwm.sv
module split_pwm
  import split_pwm_pkg::*;
#(
  parameter int W = HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2*W-1:0]   duty_set,
  output logic             pwm_out,
  output logic             period_strobe
);
  localparam int NTAP  = 1 << W;
  localparam int NRING = (NTAP / 2 < 1) ? 1 : NTAP / 2;
  localparam int DW    = 2 * W;

  logic [NTAP-1:0] below_tap;
  logic            slot_first;
  logic            slot_last;
  logic [W-1:0]    frame_q;
  logic [DW-1:0]   act_q;
  logic [W-1:0]    upper_code;
  logic [W-1:0]    lower_code;
  logic            upper_act;
  logic            lower_act;
  logic            pulse_next;
  logic            period_first;
  logic            period_last;

  tap_delay_line #(.W(W), .NTAP(NTAP), .NRING(NRING)) taps_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .below_tap  (below_tap),
    .slot_first (slot_first),
    .slot_last  (slot_last)
  );

  // Free-running period framer built from the same divider.
  quarter_divider #(.W(W)) frame_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (1'b0),
    .advance (slot_last),
    .quarter (frame_q)
  );

  assign period_first = slot_first && (frame_q == '0);
  assign period_last  = slot_last  && (frame_q == W'(NTAP - 1));

  // Code in force: taken once, at the close of the last slot of a period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           act_q <= '0;
    else if (period_last) act_q <= duty_set;
  end

  assign upper_code = act_q[DW-1:W];
  assign lower_code = act_q[W-1:0];

  coarse_slicer #(.W(W)) upper_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (upper_code),
    .slot_last (slot_last),
    .active    (upper_act)
  );

  fine_slicer #(.W(W), .NTAP(NTAP)) lower_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (lower_code),
    .window    (upper_code),
    .below_tap (below_tap),
    .slot_last (slot_last),
    .active    (lower_act)
  );

  // Combiner: lower part alone when the upper pair is empty, else merged.
  always_comb begin
    if (upper_code == '0) pulse_next = lower_act;
    else                  pulse_next = upper_act | lower_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_out       <= 1'b0;
      period_strobe <= 1'b0;
    end else begin
      pwm_out       <= pulse_next;
      period_strobe <= period_first;
    end
  end
endmodule

// File: rtl/split_pwm_chk.sv
module split_pwm_chk #(
  parameter int DW     = 4,
  parameter int PERIOD = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwm_out,
  input logic          period_strobe,
  input logic [DW-1:0] active_set
);
  localparam int CNT_W = $clog2(PERIOD) + 1;

  logic             armed;
  logic [CNT_W-1:0] gap_cnt;
  logic [CNT_W-1:0] hi_cnt;
  logic [CNT_W-1:0] exp_q;
  logic             fell_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      gap_cnt   <= '0;
      hi_cnt    <= '0;
      exp_q     <= '0;
      fell_seen <= 1'b0;
    end else if (period_strobe) begin
      armed     <= 1'b1;
      gap_cnt   <= '0;
      hi_cnt    <= CNT_W'(pwm_out);
      exp_q     <= CNT_W'(active_set);
      fell_seen <= 1'b0;
    end else begin
      gap_cnt   <= gap_cnt + 1'b1;
      hi_cnt    <= hi_cnt + CNT_W'(pwm_out);
      if ($fell(pwm_out)) fell_seen <= 1'b1;
    end
  end

  // R1: strobes are exactly PERIOD cycles apart
  assert_strobe_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (period_strobe && armed) |-> (gap_cnt == CNT_W'(PERIOD - 1)));

  // R2: high cycles in a finished period equal the code used for it
  assert_high_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_strobe && armed) |-> (hi_cnt == exp_q));

  // R3: the pulse can only begin in a strobe cycle
  assert_rise_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwm_out) && armed) |-> period_strobe);

  // R3: once low again, the output stays low until the next period
  assert_single_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fell_seen && !period_strobe) |-> !pwm_out);

  // R7: a period never ends with every cycle high
  assert_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (period_strobe && armed) |-> (hi_cnt != CNT_W'(PERIOD)));
endmodule

bind split_pwm split_pwm_chk #(.DW(2 * W), .PERIOD((1 << W) * (1 << W))) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .pwm_out       (pwm_out),
  .period_strobe (period_strobe),
  .active_set    (act_q)
);

// File: tb/split_pwm_tb_top.sv
`timescale 1ns/1ps
module split_pwm_tb_top;
  localparam int PER = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] duty_set = 4'd9;
  logic       pwm_out;
  logic       period_strobe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int          idx = 0;
  bit          armed = 0;
  int          exp_cur = 0;
  int          pending = 0;
  int          periods = 0;
  logic [PER-1:0] pattern = '0;

  always #5 clk = ~clk;

  split_pwm dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .duty_set      (duty_set),
    .pwm_out       (pwm_out),
    .period_strobe (period_strobe)
  );

  function automatic logic [PER-1:0] run_mask(int v);
    logic [PER-1:0] m;
    for (int i = 0; i < PER; i++) m[i] = (i < v);
    return m;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: samples away from the rising edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      check(!pwm_out && !period_strobe, "R6 outputs low in reset",
            {pwm_out, period_strobe}, 0);
    end else if (!done) begin
      if (period_strobe) begin
        if (armed) begin
          // R1 spacing, R2/R3/R4/R7 exact run of exp_cur cycles from strobe
          check(idx == PER, "R1 strobe spacing", idx, PER);
          check(pattern == run_mask(exp_cur),
                $sformatf("R2/R3 pulse shape code %0d", exp_cur),
                int'(pattern), int'(run_mask(exp_cur)));
          periods++;
        end
        exp_cur = pending;
        armed   = 1;
        idx     = 0;
        pattern = '0;
      end
      if (armed && idx < PER) pattern[idx] = pwm_out;
      if (armed && idx == PER - 2) pending = int'(duty_set); // R5 sample point
      idx++;
    end
  end

  task automatic set_at(int j, int v);
    do @(posedge clk); while (!(armed && idx == j));
    #1 duty_set = 4'(v);
  endtask

  task automatic wait_periods(int n);
    int target;
    target = periods + n;
    while (periods < target) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'h1234_abcd));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R6: first period after reset runs with code 0 although duty_set is 9
    wait_periods(1);
    // Directed sweep of all codes (R2, R3, R4, R7)
    for (int s = 0; s < PER; s++) set_at(3, s);
    wait_periods(2);
    // R5 boundaries: change at index 14 lands next period, at 15 one later
    set_at(14, 6);
    set_at(15, 11);
    wait_periods(1);
    set_at(15, 0);
    set_at(8, 4);
    wait_periods(1);
    // Random codes and change positions
    for (int k = 0; k < 60; k++) begin
      set_at(1 + int'($urandom % 15), int'($urandom % 16));
    end
    wait_periods(3);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      check(0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule